// File: doc/BRIEF.md
# Bus Request Grant Handshake

This block sits between an external requester and a transfer controller running in demand-transfer mode. The requester pulls an active-low request strobe for one clock per request. The block takes the request, waits through a single acceptance cycle, and then pulls an active-low bus-available output.

That output normally stays low for one cycle. When the memory side reports that the access hit a row miss in a bank that had not been precharged, the output instead stays low for a stretched interval taken from a small precharge code. A request that arrives during a grant is dropped, not queued. A request that arrives during the acceptance cycle breaks the handshake protocol and sets a sticky violation flag.

Alongside the handshake, the block registers the acknowledge and the number of the channel being serviced. The channel code is therefore valid on every clock edge at which the registered acknowledge is high.

Top module: `busreq_grant`

## Requirements
- R1: While reset is high, and after it is released with no stimulus, the outputs are avail_n=1, proto_err=0, ack_o=0 and id_o=00.
- R2: If req_n is sampled low at rising edge k while the block is idle, then avail_n is still high after edge k and goes low after edge k+1, which is exactly one acceptance cycle later.
- R3: If row_miss is low at edge k+1 (the edge at which the grant starts), then avail_n stays low for exactly one cycle.
- R4: If row_miss is high at edge k+1, then avail_n stays low for pre_code+1 cycles. The 2-bit code maps 00, 01, 10 and 11 to 1, 2, 3 and 4 cycles.
- R5: A req_n low sampled at any edge while avail_n is low, including the last grant cycle, produces no further grant and leaves proto_err unchanged.
- R6: A req_n low sampled at the edge that ends the acceptance cycle sets proto_err after that edge. The request is dropped, and the pending grant proceeds unchanged. proto_err stays set until reset.
- R7: A request sampled at the first edge after avail_n has returned high is accepted normally.
- R8: ack_o is ack_i delayed by one edge. id_o is chan_i delayed by one edge while ack_i was high, and 00 otherwise. The channel codes 00, 01, 10 and 11 denote channels 0, 1, 2 and 3.
- R9: row_miss and pre_code are used only at the grant-start edge. Changing them during a grant does not alter its length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_n | input | 1 | Active-low request strobe, one cycle per request |
| row_miss | input | 1 | Row miss in a non-precharged bank, sampled at grant start |
| pre_code | input | PRE_W | Precharge interval code, hold = code+1 cycles |
| ack_i | input | 1 | Transfer acknowledge |
| chan_i | input | ID_W | Channel number being serviced |
| avail_n | output | 1 | Active-low bus-available |
| ack_o | output | 1 | Registered acknowledge |
| id_o | output | ID_W | Registered channel code, zero when ack_o is low |
| proto_err | output | 1 | Sticky early-repeat violation flag |

## Verification
The bench builds the block with its default widths: a 2-bit precharge code and a 2-bit channel code. With these widths every stretched hold length from one to four cycles can be reached, and so can every channel number, each in a few dozen cycles. Both the normal and the stretched grant can therefore be walked exhaustively. This also covers the drop of a request in the final grant cycle and the earliest back-to-back acceptance after it.

// File: rtl/busreq_grant_pkg.sv
package busreq_grant_pkg;

    localparam int unsigned BRG_PRE_W = 2;
    localparam int unsigned BRG_ID_W  = 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCEPT = 2'd1,
        ST_GRANT  = 2'd2
    } brg_state_e;

    // Number of low cycles of the available output for one grant.
    function automatic int unsigned hold_len(input logic miss, input int unsigned code);
        return miss ? (code + 1) : 1;
    endfunction

endpackage

// File: rtl/busreq_grant_timer.sv
module busreq_grant_timer #(
    parameter int unsigned PRE_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [PRE_W-1:0] load_val,
    output logic             last
);
    logic [PRE_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q == '0);
endmodule

// File: rtl/busreq_grant_fsm.sv
module busreq_grant_fsm
    import busreq_grant_pkg::*;
#(
    parameter int unsigned PRE_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_n,
    input  logic             row_miss,
    input  logic [PRE_W-1:0] pre_code,
    input  logic             hold_last,
    output brg_state_e       st,
    output logic             load,
    output logic [PRE_W-1:0] load_val,
    output logic             avail_n,
    output logic             viol
);
    brg_state_e st_q, st_d;
    logic       viol_q;
    logic       req_hit;

    assign req_hit = ~req_n;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:   if (req_hit) st_d = ST_ACCEPT;
            ST_ACCEPT: st_d = ST_GRANT;
            ST_GRANT:  if (hold_last) st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            viol_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_ACCEPT && req_hit) begin
                viol_q <= 1'b1;
            end
        end
    end

    assign load     = (st_q == ST_ACCEPT);
    assign load_val = PRE_W'(hold_len(row_miss, int'(pre_code)) - 1);
    assign avail_n  = (st_q != ST_GRANT);
    assign viol     = viol_q;
    assign st       = st_q;
endmodule

// File: rtl/busreq_grant_tag.sv
module busreq_grant_tag #(
    parameter int unsigned ID_W = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ack_i,
    input  logic [ID_W-1:0] chan_i,
    output logic            ack_o,
    output logic [ID_W-1:0] id_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ack_o <= 1'b0;
            id_o  <= '0;
        end else begin
            ack_o <= ack_i;
            id_o  <= ack_i ? chan_i : '0;
        end
    end
endmodule

// File: rtl/busreq_grant.sv
module busreq_grant
    import busreq_grant_pkg::*;
#(
    parameter int unsigned PRE_W = BRG_PRE_W,
    parameter int unsigned ID_W  = BRG_ID_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_n,
    input  logic             row_miss,
    input  logic [PRE_W-1:0] pre_code,
    input  logic             ack_i,
    input  logic [ID_W-1:0]  chan_i,
    output logic             avail_n,
    output logic             ack_o,
    output logic [ID_W-1:0]  id_o,
    output logic             proto_err
);
    brg_state_e       st_w;
    logic             load_w;
    logic [PRE_W-1:0] load_val_w;
    logic             last_w;

    busreq_grant_fsm #(.PRE_W(PRE_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_n     (req_n),
        .row_miss  (row_miss),
        .pre_code  (pre_code),
        .hold_last (last_w),
        .st        (st_w),
        .load      (load_w),
        .load_val  (load_val_w),
        .avail_n   (avail_n),
        .viol      (proto_err)
    );

    busreq_grant_timer #(.PRE_W(PRE_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load_w),
        .load_val (load_val_w),
        .last     (last_w)
    );

    busreq_grant_tag #(.ID_W(ID_W)) u_tag (
        .clk    (clk),
        .rst    (rst),
        .ack_i  (ack_i),
        .chan_i (chan_i),
        .ack_o  (ack_o),
        .id_o   (id_o)
    );
endmodule

// File: rtl/busreq_grant_chk.sv
module busreq_grant_chk
    import busreq_grant_pkg::*;
#(
    parameter int unsigned PRE_W = 2,
    parameter int unsigned ID_W  = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             req_n,
    input logic             row_miss,
    input logic [PRE_W-1:0] pre_code,
    input logic             ack_i,
    input logic [ID_W-1:0]  chan_i,
    input logic             avail_n,
    input logic             ack_o,
    input logic [ID_W-1:0]  id_o,
    input logic             proto_err,
    input brg_state_e       st
);
    localparam int unsigned LW = PRE_W + 2;

    logic [LW-1:0] low_cnt;
    logic [LW-1:0] exp_len;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
            exp_len <= LW'(1);
        end else begin
            low_cnt <= avail_n ? '0 : low_cnt + 1'b1;
            if (st == ST_ACCEPT) begin
                exp_len <= row_miss ? (LW'(pre_code) + 1'b1) : LW'(1);
            end
        end
    end

    assert_accept_latency_R2: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && !req_n) |=> (avail_n ##1 !avail_n));

    assert_single_grant_R3: assert property (@(posedge clk) disable iff (rst)
        ($fell(avail_n) && !$past(row_miss)) |=> avail_n);

    assert_hold_length_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(avail_n) |-> (low_cnt == exp_len));

    assert_drop_in_grant_R5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_GRANT && !req_n) |=> (st != ST_ACCEPT));

    assert_flag_set_R6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ACCEPT && !req_n) |=> proto_err);

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> proto_err);

    assert_id_follow_R8: assert property (@(posedge clk) disable iff (rst)
        ack_i |=> (ack_o && id_o == $past(chan_i)));

    assert_id_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !ack_i |=> (!ack_o && id_o == '0));
endmodule

bind busreq_grant busreq_grant_chk #(.PRE_W(PRE_W), .ID_W(ID_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_n     (req_n),
    .row_miss  (row_miss),
    .pre_code  (pre_code),
    .ack_i     (ack_i),
    .chan_i    (chan_i),
    .avail_n   (avail_n),
    .ack_o     (ack_o),
    .id_o      (id_o),
    .proto_err (proto_err),
    .st        (st_w)
);

// File: tb/busreq_grant_tb.sv
`timescale 1ns/1ps
module busreq_grant_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_n = 1'b1;
    logic       row_miss = 1'b0;
    logic [1:0] pre_code = 2'b00;
    logic       ack_i = 1'b0;
    logic [1:0] chan_i = 2'b00;
    logic       avail_n;
    logic       ack_o;
    logic [1:0] id_o;
    logic       proto_err;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    busreq_grant #(.PRE_W(2), .ID_W(2)) dut_i (
        .clk(clk), .rst(rst), .req_n(req_n), .row_miss(row_miss),
        .pre_code(pre_code), .ack_i(ack_i), .chan_i(chan_i),
        .avail_n(avail_n), .ack_o(ack_o), .id_o(id_o), .proto_err(proto_err)
    );

    // {row_miss, pre_code[1:0], expected hold length[2:0]}
    localparam int NV = 8;
    localparam logic [5:0] VEC [NV] = '{
        {1'b0, 2'd0, 3'd1}, {1'b0, 2'd3, 3'd1}, {1'b1, 2'd0, 3'd1}, {1'b1, 2'd1, 3'd2},
        {1'b1, 2'd2, 3'd3}, {1'b1, 2'd3, 3'd4}, {1'b0, 2'd2, 3'd1}, {1'b1, 2'd3, 3'd4}
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Issue one strobe; returns at the negedge after avail_n returned high.
    task automatic run_req(input logic rm, input logic [1:0] pc, input int len, input string tag);
        @(negedge clk);
        req_n = 1'b0; row_miss = rm; pre_code = pc;
        @(negedge clk);
        req_n = 1'b1;
        check({tag, " R2 acceptance cycle avail_n"}, avail_n, 1);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            check({tag, " R3/R4 grant low"}, avail_n, 0);
        end
        @(negedge clk);
        check({tag, " R3/R4 grant end"}, avail_n, 1);
    endtask

    task automatic quiet(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check({tag, " no extra grant"}, avail_n, 1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset avail_n", avail_n, 1);
        check("R1 reset proto_err", proto_err, 0);
        check("R1 reset ack_o", ack_o, 0);
        check("R1 reset id_o", id_o, 0);
        rst = 1'b0;
        quiet(2, "R1 idle");

        for (int v = 0; v < NV; v++) begin
            run_req(VEC[v][5], VEC[v][4:3], int'(VEC[v][2:0]), $sformatf("vec%0d", v));
        end
        check("R5 no flag after clean vectors", proto_err, 0);

        // R5: request in the middle of a stretched grant is dropped.
        @(negedge clk); req_n = 1'b0; row_miss = 1'b1; pre_code = 2'd3;
        @(negedge clk); req_n = 1'b1;
        @(negedge clk); req_n = 1'b0; check("R5 stretched low 1", avail_n, 0);
        @(negedge clk); req_n = 1'b1; check("R5 stretched low 2", avail_n, 0);
        @(negedge clk); check("R5 stretched low 3", avail_n, 0);
        @(negedge clk); check("R5 stretched low 4", avail_n, 0);
        quiet(5, "R5 mid-grant drop");
        check("R5 no flag on drop", proto_err, 0);

        // R5: request in the final cycle of a one-cycle grant is dropped.
        @(negedge clk); req_n = 1'b0; row_miss = 1'b0;
        @(negedge clk); req_n = 1'b1;
        @(negedge clk); req_n = 1'b0; check("R5 last-cycle grant low", avail_n, 0);
        @(negedge clk); req_n = 1'b1; check("R5 last-cycle end", avail_n, 1);
        quiet(4, "R5 last-cycle drop");
        check("R5 no flag last-cycle", proto_err, 0);

        // R7: back-to-back at the first edge after the grant.
        run_req(1'b1, 2'd1, 2, "R7 first");
        req_n = 1'b0; row_miss = 1'b0;
        @(negedge clk); req_n = 1'b1; check("R7 second acceptance", avail_n, 1);
        @(negedge clk); check("R7 second grant", avail_n, 0);
        @(negedge clk); check("R7 second end", avail_n, 1);

        // R9: changing row_miss / pre_code mid-grant does not shorten it.
        @(negedge clk); req_n = 1'b0; row_miss = 1'b1; pre_code = 2'd2;
        @(negedge clk); req_n = 1'b1;
        @(negedge clk); row_miss = 1'b0; pre_code = 2'd0; check("R9 low 1", avail_n, 0);
        @(negedge clk); check("R9 low 2", avail_n, 0);
        @(negedge clk); check("R9 low 3", avail_n, 0);
        @(negedge clk); check("R9 end", avail_n, 1);

        // R6: strobe held two cycles -> early repeat flagged, one grant only.
        @(negedge clk); req_n = 1'b0; row_miss = 1'b0;
        @(negedge clk); check("R6 acceptance, flag still clear", proto_err, 0);
        @(negedge clk); req_n = 1'b1;
        check("R6 flag set", proto_err, 1);
        check("R6 grant proceeds", avail_n, 0);
        quiet(4, "R6 repeat dropped");
        run_req(1'b1, 2'd1, 2, "R6 after violation");
        check("R6 flag sticky", proto_err, 1);

        // R8: channel tagging.
        for (int c = 0; c < 4; c++) begin
            @(negedge clk); ack_i = 1'b1; chan_i = 2'(c);
            @(negedge clk);
            check($sformatf("R8 ack_o ch%0d", c), ack_o, 1);
            check($sformatf("R8 id_o ch%0d", c), id_o, c);
        end
        ack_i = 1'b0; chan_i = 2'd3;
        @(negedge clk);
        check("R8 ack_o low", ack_o, 0);
        check("R8 id_o zero when no ack", id_o, 0);

        // R1: reset clears the sticky flag.
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset clears proto_err", proto_err, 0);
        check("R1 reset avail_n again", avail_n, 1);
        rst = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule